// File: doc/BRIEF.md
# Dual-Processor Interrupt Steering Unit

This block sits between the interrupt sources of a board and two processors, of which only one runs at a time. It takes a maskable request, a bus-level non-maskable line and a power-fail line, and presents them to whichever processor the active-CPU select names. The maskable request passes through a clocked retiming stage. The two non-maskable sources are active-low. Each is brought into the clock domain through a synchroniser chain, the two are merged, and their merged assertion becomes a one-cycle rising-edge pulse. That pulse goes to the trap input of processor A or to the NMI input of processor B.

The block also drives a swap request, which software can enable through a mask bit from the processor swap port. When the mask is set and any interrupt is pending, the swap request asks the system to disable processor A and enable processor B. A static enable decides whether the power-fail line counts as a non-maskable source. The processor that is not selected sees all of its interrupt pins held low.

Top module: `dual_cpu_irq_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all five outputs (`a_intr`, `a_trap`, `b_intr`, `b_nmi`, `swap_force`) are low.
- R2: The maskable request is retimed by one clock. A level on `irq_raw` sampled at a rising edge appears on the selected interrupt output right after that edge, not before it.
- R3: With `sel_b` = 0 the retimed request drives `a_intr`. With `sel_b` = 1 it drives `b_intr`. The selection acts combinationally on the outputs.
- R4: When `nmi_bus_n` falls from 1 to 0, exactly one pulse one cycle long appears. It is visible after the second rising edge that samples the low level: on `a_trap` when `sel_b` = 0, or on `b_nmi` when `sel_b` = 1.
- R5: A non-maskable source held low produces no further pulse. A new pulse needs every enabled source to go high and then low again.
- R6: With `pwrfail_en` = 1, a falling `pwrfail_n` acts exactly like a falling `nmi_bus_n`. With `pwrfail_en` = 0, `pwrfail_n` has no effect on `a_trap`, `b_nmi` or `swap_force`.
- R7: `swap_force` is high exactly when `swap_mask` = 1 and either the retimed maskable request is high or a synchronised enabled non-maskable source is low. With `swap_mask` = 0, `swap_force` is low.
- R8: The outputs of the processor that is not selected stay low at all times.
- R9: When a second non-maskable source falls while the first is already low, no additional pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_raw | input | 1 | Maskable interrupt request, active high |
| nmi_bus_n | input | 1 | Bus non-maskable interrupt, active low, asynchronous |
| pwrfail_n | input | 1 | Power-fail warning, active low, asynchronous |
| pwrfail_en | input | 1 | Static enable that counts power-fail as a non-maskable source |
| sel_b | input | 1 | Active processor: 0 = A, 1 = B |
| swap_mask | input | 1 | Swap mask bit from the processor swap port |
| a_intr | output | 1 | Maskable interrupt to processor A |
| a_trap | output | 1 | Trap pulse to processor A |
| b_intr | output | 1 | Maskable interrupt to processor B |
| b_nmi | output | 1 | NMI pulse to processor B |
| swap_force | output | 1 | Request to disable A and enable B |

## Verification
The hardest situation to reach is a pair of non-maskable sources that overlap. One source is already low and its pulse has already gone by, then the second falls and must produce nothing. A second hard case is a select change that lands between the synchroniser and the edge pulse. The directed part of the stimulus holds `nmi_bus_n` low across the synchroniser delay and then drops `pwrfail_n`. It also flips `sel_b` in the cycle the pulse is due. A long random phase then toggles all inputs with low-probability edges and checks every output each cycle against a reference model in the bench.

// File: rtl/intr_route_pkg.sv
package intr_route_pkg;

  typedef enum logic {
    CPU_A = 1'b0,
    CPU_B = 1'b1
  } cpu_sel_e;

  typedef struct packed {
    logic a_intr;
    logic a_trap;
    logic b_intr;
    logic b_nmi;
  } cpu_pins_t;

  // Merge of the non-maskable sources, inputs already active-high
  function automatic logic nmi_level_of(logic bus_act, logic pf_act, logic pf_en);
    return bus_act | (pf_act & pf_en);
  endfunction

  // Swap request: mask gates the combined pending indicator
  function automatic logic swap_request(logic mask, logic irq, logic nmi_lvl);
    return mask & (irq | nmi_lvl);
  endfunction

  // Steering of both interrupt kinds onto the selected processor
  function automatic cpu_pins_t steer_pins(cpu_sel_e who, logic irq, logic nmi_pulse);
    cpu_pins_t p;
    p = '0;
    if (who == CPU_A) begin
      p.a_intr = irq;
      p.a_trap = nmi_pulse;
    end else begin
      p.b_intr = irq;
      p.b_nmi  = nmi_pulse;
    end
    return p;
  endfunction

endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= d;
      end
      assign q = r_q;
    end else begin : g_chain
      logic [STAGES-1:0] r_chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_chain <= {STAGES{RESET_VAL}};
        else        r_chain <= {r_chain[STAGES-2:0], d};
      end
      assign q = r_chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/intr_edge.sv
module intr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);

  logic level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  assign pulse = level & ~level_d;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R5

endmodule

// File: rtl/intr_steer.sv
module intr_steer
  import intr_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_b,
  input  logic irq_q,
  input  logic nmi_pulse,
  input  logic nmi_level,
  input  logic swap_mask,
  output logic a_intr,
  output logic a_trap,
  output logic b_intr,
  output logic b_nmi,
  output logic swap_force
);

  cpu_pins_t pins;
  cpu_sel_e  who;

  assign who  = sel_b ? CPU_B : CPU_A;
  assign pins = steer_pins(who, irq_q, nmi_pulse);

  assign a_intr     = pins.a_intr;
  assign a_trap     = pins.a_trap;
  assign b_intr     = pins.b_intr;
  assign b_nmi      = pins.b_nmi;
  assign swap_force = swap_request(swap_mask, irq_q, nmi_level);

  AST_A_QUIET_WHEN_B: assert property (@(posedge clk) disable iff (!rst_n)
    sel_b |-> (!a_intr && !a_trap)); // R8
  AST_B_QUIET_WHEN_A: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_b |-> (!b_intr && !b_nmi)); // R8
  AST_SWAP_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    swap_force |-> swap_mask); // R7
  AST_NMI_IMPLIES_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_mask && (a_trap || b_nmi)) |-> swap_force); // R7

endmodule

// File: rtl/dual_cpu_irq_router.sv
module dual_cpu_irq_router
  import intr_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_STAGES  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw,
  input  logic nmi_bus_n,
  input  logic pwrfail_n,
  input  logic pwrfail_en,
  input  logic sel_b,
  input  logic swap_mask,
  output logic a_intr,
  output logic a_trap,
  output logic b_intr,
  output logic b_nmi,
  output logic swap_force
);

  localparam int NSRC = 2;

  logic            irq_q;
  logic [NSRC-1:0] src_n_raw;
  logic [NSRC-1:0] src_n_sync;
  logic            nmi_level;
  logic            nmi_pulse;
  logic            armed;

  assign src_n_raw = {pwrfail_n, nmi_bus_n};

  intr_sync #(.STAGES(IRQ_STAGES), .RESET_VAL(1'b0)) u_irq_retime (
    .clk(clk), .rst_n(rst_n), .d(irq_raw), .q(irq_q)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_nmi_src
      intr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(src_n_raw[gi]), .q(src_n_sync[gi])
      );
    end
  endgenerate

  assign nmi_level = nmi_level_of(~src_n_sync[0], ~src_n_sync[1], pwrfail_en);

  intr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level(nmi_level), .pulse(nmi_pulse)
  );

  intr_steer u_steer (
    .clk(clk), .rst_n(rst_n), .sel_b(sel_b), .irq_q(irq_q),
    .nmi_pulse(nmi_pulse), .nmi_level(nmi_level), .swap_mask(swap_mask),
    .a_intr(a_intr), .a_trap(a_trap), .b_intr(b_intr), .b_nmi(b_nmi),
    .swap_force(swap_force)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  generate
    if (IRQ_STAGES == 1) begin : g_irq_chk
      AST_IRQ_RETIMED: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((a_intr | b_intr) == $past(irq_raw))); // R2
    end
  endgenerate

  AST_NMI_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_trap && b_nmi)); // R8
  AST_NMI_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (a_trap || b_nmi) |=> !(a_trap || b_nmi)); // R5

endmodule

// File: tb/test_dual_cpu_irq_router.sv
module test_dual_cpu_irq_router;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic irq_raw, nmi_bus_n, pwrfail_n, pwrfail_en, sel_b, swap_mask;
  logic a_intr, a_trap, b_intr, b_nmi, swap_force;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_cpu_irq_router i_dual_cpu_irq_router (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .nmi_bus_n(nmi_bus_n),
    .pwrfail_n(pwrfail_n), .pwrfail_en(pwrfail_en), .sel_b(sel_b),
    .swap_mask(swap_mask), .a_intr(a_intr), .a_trap(a_trap),
    .b_intr(b_intr), .b_nmi(b_nmi), .swap_force(swap_force)
  );

  // Reference model built from the requirements
  logic m_irq;
  logic [1:0] m_bus, m_pf;
  logic m_prev;

  function automatic logic exp_level(logic [1:0] b, logic [1:0] p, logic en);
    return (b[1] == 1'b0) || (en && (p[1] == 1'b0));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irq <= 1'b0; m_bus <= 2'b11; m_pf <= 2'b11; m_prev <= 1'b0;
    end else begin
      m_irq  <= irq_raw;
      m_bus  <= {m_bus[0], nmi_bus_n};
      m_pf   <= {m_pf[0], pwrfail_n};
      m_prev <= exp_level(m_bus, m_pf, pwrfail_en);
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic model_check();
    logic lvl, pul;
    lvl = exp_level(m_bus, m_pf, pwrfail_en);
    pul = lvl && !m_prev;
    chk("R3", "a_intr", a_intr, !sel_b && m_irq);
    chk("R3", "b_intr", b_intr, sel_b && m_irq);
    chk("R4", "a_trap", a_trap, !sel_b && pul);
    chk("R4", "b_nmi",  b_nmi,  sel_b && pul);
    chk("R7", "swap_force", swap_force, swap_mask && (m_irq || lvl));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; irq_raw = 1'b0; nmi_bus_n = 1'b1; pwrfail_n = 1'b1;
    pwrfail_en = 1'b0; sel_b = 1'b0; swap_mask = 1'b0;
    repeat (3) step();
    chk("R1", "a_intr rst", a_intr, 1'b0);
    chk("R1", "a_trap rst", a_trap, 1'b0);
    chk("R1", "b_intr rst", b_intr, 1'b0);
    chk("R1", "b_nmi rst",  b_nmi,  1'b0);
    chk("R1", "swap rst",   swap_force, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1", "swap after rst", swap_force, 1'b0);

    // R2 / R3: retime and steering
    irq_raw = 1'b1;
    #1 chk("R2", "a_intr before edge", a_intr, 1'b0);
    step();
    chk("R2", "a_intr after edge", a_intr, 1'b1);
    chk("R8", "b_intr idle", b_intr, 1'b0);
    sel_b = 1'b1;
    #1 chk("R3", "b_intr sel", b_intr, 1'b1);
    chk("R8", "a_intr idle", a_intr, 1'b0);
    swap_mask = 1'b1;
    #1 chk("R7", "swap irq", swap_force, 1'b1);
    irq_raw = 1'b0; swap_mask = 1'b0; sel_b = 1'b0;
    step(); step();

    // R4 / R5: bus NMI on A
    nmi_bus_n = 1'b0;
    step(); chk("R4", "a_trap early", a_trap, 1'b0);
    step(); chk("R4", "a_trap pulse", a_trap, 1'b1);
    chk("R8", "b_nmi idle", b_nmi, 1'b0);
    step(); chk("R5", "a_trap once", a_trap, 1'b0);
    swap_mask = 1'b1;
    #1 chk("R7", "swap nmi level", swap_force, 1'b1);
    swap_mask = 1'b0;
    // R9: second source falls while first still low
    pwrfail_en = 1'b1; pwrfail_n = 1'b0;
    repeat (4) begin step(); chk("R9", "no second pulse", a_trap | b_nmi, 1'b0); end
    nmi_bus_n = 1'b1; pwrfail_n = 1'b1;
    repeat (4) step();

    // R6: power-fail alone, enabled, routed to B
    sel_b = 1'b1; pwrfail_n = 1'b0;
    step(); step();
    chk("R6", "b_nmi pf", b_nmi, 1'b1);
    chk("R8", "a_trap idle", a_trap, 1'b0);
    pwrfail_n = 1'b1;
    repeat (4) step();
    // R6: power-fail disabled has no effect
    pwrfail_en = 1'b0; swap_mask = 1'b1; pwrfail_n = 1'b0;
    repeat (5) begin
      step();
      chk("R6", "pf masked nmi", b_nmi | a_trap, 1'b0);
      chk("R6", "pf masked swap", swap_force, 1'b0);
    end
    pwrfail_n = 1'b1; swap_mask = 1'b0;
    repeat (4) step();

    // Select flip on the cycle the pulse is due
    sel_b = 1'b0; nmi_bus_n = 1'b0;
    step(); sel_b = 1'b1;
    step();
    chk("R4", "pulse follows sel", b_nmi, 1'b1);
    chk("R8", "a_trap after flip", a_trap, 1'b0);
    nmi_bus_n = 1'b1;
    repeat (4) step();

    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      model_check();
      if (($urandom % 4) == 0) irq_raw = ~irq_raw;
      if (($urandom % 9) == 0) nmi_bus_n = ~nmi_bus_n;
      if (($urandom % 11) == 0) pwrfail_n = ~pwrfail_n;
      if (($urandom % 200) == 0) pwrfail_en = ~pwrfail_en;
      if (($urandom % 7) == 0) sel_b = ~sel_b;
      if (($urandom % 5) == 0) swap_mask = ~swap_mask;
      #1 model_check();
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule